// File: doc/BRIEF.md
# Single-Wire Pulse-Width Serial Encoder

This block drives one output line that carries both the shift clock and the data for an external latching shift register. Every rising edge of the line clocks the register. The register's data input sees a slowly filtered copy of the line. A brief low dip therefore leaves the filtered level high and shifts in a one. A low held for a full settle interval lets the filter discharge, so the rising edge that follows shifts in a zero.

A client presents a byte and pulses `start` while the block is idle. The block sends a fixed marker one, then the seven low bits of the byte, most significant first. After that it runs the post-frame sequence that the `hw_clear` input selected at start.

- In software-clear mode, the block holds the line high for one settle interval so that the latch and enable rise. It then holds the line low for one settle interval so that they fall. It shifts eight zeros with short pulses, then holds the line high for one settle interval so the filter recovers.
- In hardware-clear mode, the frame ends with the last bit, because external logic clears the register.

Top module: `sw1_serial_encoder`

## Requirements
- R1: After reset and whenever `busy` is low, `line_o` is high. `busy` and `done` are low after reset.
- R2: A `start` seen while idle is accepted. `busy` rises on the next cycle and `line_o` goes low in that same cycle. `frame[7]` is ignored: the first bit sent is always a one, followed by `frame[6]` down to `frame[0]`. `hw_clear` is sampled only at acceptance.
- R3: A one bit is `line_o` low for PULSE_CYC cycles, then high for PULSE_CYC cycles.
- R4: A zero bit is `line_o` low for SETTLE_CYC cycles, then high for SETTLE_CYC cycles.
- R5: With `hw_clear` = 0, after the last bit the line stays high for a further SETTLE_CYC cycles and is then low for SETTLE_CYC cycles. The external register therefore latches exactly once, holding the sent frame.
- R6: With `hw_clear` = 0, eight clear pulses follow, each low PULSE_CYC then high PULSE_CYC, and then the line is high for SETTLE_CYC cycles. The external register shifts in eight zeros and ends empty. The whole operation lasts 3·SETTLE_CYC + 16·PULSE_CYC cycles more than the bits.
- R7: With `hw_clear` = 1, the operation ends right after the high phase of the last bit. There are exactly eight rising edges.
- R8: `start`, `frame` and `hw_clear` are ignored while `busy` is high.
- R9: `done` is high for exactly one cycle, in the first cycle after `busy` falls, with `line_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to send `frame` |
| frame | input | 8 | Byte to send; bit 7 is replaced by the marker |
| hw_clear | input | 1 | 1 selects hardware-clear mode, 0 selects software-clear mode |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| line_o | output | 1 | Combined clock/data line |

## Verification
The assertions check on every cycle that the line idles high, that each accepted operation begins with a low phase, that `done` is a lone pulse after `busy` falls, and that no low run exceeds SETTLE_CYC + PULSE_CYC. Only the bench can show the bit encoding, the frame timing, and the behaviour of the external register. It models the filtered data node, the shift register, and the latch/enable gate, and feeds them from the line. For every byte in both modes it compares the bits shifted in, the single latched value, the emptied register, and the cycle count against values it computes itself. One run of the sweep also pokes `start` while the block is busy.

// File: rtl/sw1_serial_encoder.sv
module sw1_serial_encoder #(
  parameter int SETTLE_CYC = 250,
  parameter int PULSE_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] frame,
  input  logic       hw_clear,
  output logic       busy,
  output logic       done,
  output logic       line_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] S1 = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] P1 = CW'(PULSE_CYC - 1);

  typedef enum logic [2:0] {
    IDLE, BIT_LO, BIT_HI, LATCH_HI, LATCH_LO, CLR_LO, CLR_HI, RECOV
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [7:0]    sh;
  logic [2:0]    idx;
  logic          hw;
  logic          tick;

  assign tick   = (cnt == '0);
  assign busy   = (st != IDLE);
  assign line_o = !(st == BIT_LO || st == LATCH_LO || st == CLR_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= IDLE;
      cnt  <= '0;
      sh   <= '0;
      idx  <= '0;
      hw   <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          sh  <= {1'b1, frame[6:0]};
          idx <= '0;
          hw  <= hw_clear;
          cnt <= P1;
          st  <= BIT_LO;
        end
        BIT_LO: if (tick) begin
          cnt <= sh[7] ? P1 : S1;
          st  <= BIT_HI;
        end else cnt <= cnt - 1'b1;
        BIT_HI: if (tick) begin
          if (idx == 3'd7) begin
            if (hw) begin
              st   <= IDLE;
              done <= 1'b1;
            end else begin
              cnt <= S1;
              st  <= LATCH_HI;
            end
          end else begin
            idx <= idx + 1'b1;
            sh  <= {sh[6:0], 1'b0};
            cnt <= sh[6] ? P1 : S1;
            st  <= BIT_LO;
          end
        end else cnt <= cnt - 1'b1;
        LATCH_HI: if (tick) begin
          cnt <= S1;
          st  <= LATCH_LO;
        end else cnt <= cnt - 1'b1;
        LATCH_LO: if (tick) begin
          cnt <= P1;
          idx <= '0;
          st  <= CLR_LO;
        end else cnt <= cnt - 1'b1;
        CLR_LO: if (tick) begin
          cnt <= P1;
          st  <= CLR_HI;
        end else cnt <= cnt - 1'b1;
        CLR_HI: if (tick) begin
          if (idx == 3'd7) begin
            cnt <= S1;
            st  <= RECOV;
          end else begin
            idx <= idx + 1'b1;
            cnt <= P1;
            st  <= CLR_LO;
          end
        end else cnt <= cnt - 1'b1;
        RECOV: if (tick) begin
          st   <= IDLE;
          done <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sw1_encoder_chk.sv
module sw1_encoder_chk #(
  parameter int SETTLE_CYC = 250,
  parameter int PULSE_CYC  = 2
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic line_o
);
  int lowrun;
  always_ff @(posedge clk) begin
    if (!rst_n) lowrun <= 0;
    else        lowrun <= line_o ? 0 : lowrun + 1;
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> line_o); // R1
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> (busy && !line_o)); // R2
  AST_LOW_MAX: assert property (@(posedge clk) disable iff (!rst_n) !line_o |-> (lowrun < SETTLE_CYC + PULSE_CYC)); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && line_o)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R9
endmodule

bind sw1_serial_encoder sw1_encoder_chk #(.SETTLE_CYC(SETTLE_CYC), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .line_o(line_o)
);

// File: tb/sw1_serial_encoder_tb.sv
module sw1_serial_encoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int S = 6;
  localparam int P = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, hw_clear = 1'b0;
  logic [7:0] frame = 8'h00;
  logic busy, done, line_o;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw1_serial_encoder #(.SETTLE_CYC(S), .PULSE_CYC(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .frame(frame), .hw_clear(hw_clear),
    .busy(busy), .done(done), .line_o(line_o)
  );

  // external register model
  logic       mode_hw = 1'b0;
  logic       prev_line = 1'b1, filt = 1'b1, en = 1'b0;
  int         lowrun = 0, highrun = 100;
  logic [7:0] sreg = 8'h00, latch_val = 8'h00;
  logic [15:0] cap = 16'h0;
  int edges = 0, latch_cnt = 0, busy_cyc = 0, done_cnt = 0, done_bad = 0;

  always @(negedge clk) if (rst_n) begin
    if (busy) busy_cyc++;
    if (done) begin done_cnt++; if (busy || !line_o) done_bad++; end
    if (!line_o) begin
      lowrun++; highrun = 0;
      if (lowrun >= S) filt = 1'b0;
    end else begin
      if (!prev_line) begin
        edges++;
        cap  = {cap[14:0], filt};
        sreg = {sreg[6:0], filt};
        if (mode_hw && sreg[7]) begin
          latch_cnt++; latch_val = sreg; sreg = 8'h00;
        end
      end
      highrun++; lowrun = 0;
      if (highrun >= S) filt = 1'b1;
    end
    if (!mode_hw) begin
      if (!en && highrun >= S && sreg[7] && line_o) begin latch_cnt++; latch_val = sreg; end
      en = (highrun >= S) && sreg[7] && line_o;
    end
    prev_line = line_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [7:0] f, input bit hw, input bit poke);
    logic [7:0] sent;
    int exp_cyc;
    sent = {1'b1, f[6:0]};
    exp_cyc = 0;
    for (int i = 0; i < 8; i++) exp_cyc += sent[i] ? 2*P : 2*S;
    if (!hw) exp_cyc += 3*S + 16*P;
    @(posedge clk); #1;
    edges = 0; latch_cnt = 0; busy_cyc = 0; done_cnt = 0; done_bad = 0; cap = '0;
    mode_hw = hw;
    start = 1'b1; frame = f; hw_clear = hw;
    @(posedge clk); #1;
    start = 1'b0; frame = ~f; hw_clear = ~hw;
    for (int k = 0; k < 400 && done_cnt == 0; k++) begin
      @(posedge clk); #1;
      start = (poke && (k == 3 || k == 20));
    end
    start = 1'b0;
    @(posedge clk); #1;
    check(busy_cyc == exp_cyc, hw ? "R7 cycles" : "R6 cycles", busy_cyc, exp_cyc);
    check(edges == (hw ? 8 : 16), hw ? "R7 edges" : "R6 edges", edges, hw ? 8 : 16);
    if (hw) check(cap[7:0] == sent, "R2 R3 R4 bits", cap[7:0], sent);
    else    check(cap == {sent, 8'h00}, "R2 R3 R4 R6 bits", cap, {sent, 8'h00});
    check(latch_cnt == 1 && latch_val == sent, "R5 latch", {latch_cnt, latch_val}, {1, sent});
    check(sreg == 8'h00, "R6 cleared", sreg, 0);
    check(done_cnt == 1 && done_bad == 0, "R9 done", done_cnt, 1);
    check(!busy && line_o, "R1 idle", {busy, line_o}, 1);
  endtask

  initial begin
    int seen = 0;
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(line_o == 1'b1, "R1 reset line", line_o, 1);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    check(done == 1'b0, "R1 reset done", done, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 256; v++)
        run_frame(8'(v), m[0], v == 8'h5A); // R8 poke while busy
    run_frame(8'h00, 1'b0, 1'b1); // R8 R4 all zeros
    run_frame(8'h7F, 1'b1, 1'b1); // R8 R3 all ones
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule